// File: doc/BRIEF.md
# Snooping Pseudo-DMA Bridge

This block connects an 8-bit processor's external memory bus to a peripheral data port so that a block of bytes can move between memory and the peripheral without a DMA engine. The processor runs plain load or store loops and serves only as an address generator. The bridge watches those memory cycles. When a transfer is enabled, it turns the processor's own memory strobes into peripheral strobes in the same cycle.

In the output direction, each memory read also acts as a peripheral write strobe, so the peripheral captures the byte that the memory is placing on the bus. In the input direction, each memory write also acts as a peripheral read strobe. The processor's bus driver is isolated, the memory receives the peripheral's byte, and a wait request stretches the short write pulse. A transfer can be enabled from a port pin, from an address tag in the high address bits that the memory does not decode, or from either one. Every external access takes at least three processor clocks, which gives about 2.66 MB/s at 8 MHz.

Top module: `pdma_bridge`

## Requirements
- R1: When a transfer is enabled, the direction is output (0) and `cpu_rd` is high, `per_wr` is high in that same cycle. `per_dout` always equals `mem_rdata`.
- R2: When a transfer is enabled, the direction is input (1) and `cpu_wr` is high, `per_rd` is high in that same cycle, `mem_wdata` equals `per_din` and `cpu_drv_en` is low.
- R3: On every other write, `mem_wdata` equals `cpu_dout` and `cpu_drv_en` follows `cpu_wr`. When `cpu_wr` is low, `cpu_drv_en` is low.
- R4: When a transfer is not enabled, `per_wr` and `per_rd` both stay low, whatever the strobes do.
- R5: With the default `EN_MODE` (2), a transfer is enabled when `en_pin` is high or when address bit 15 equals 1. `mem_addr` is `cpu_addr[14:0]`.
- R6: `cpu_wait` is high during the first `WAIT_CYC` cycles (default 1) of each continuous input-direction peripheral read strobe. It is low at all other times.
- R7: The direction in use is the value `dir_in` had at the last clock edge where both `cpu_rd` and `cpu_wr` were low. A change during a strobe has no effect until the strobe ends.
- R8: Synchronous reset `rst` sets the direction to output and clears the wait count. After reset, an idle bus drives `per_wr`, `per_rd` and `cpu_wait` low.
- R9: A strobe that does not match the latched direction produces no peripheral strobe. That is, a read in the input direction gives no `per_wr`, and a write in the output direction gives no `per_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_rd | input | 1 | Processor memory read strobe, active high |
| cpu_wr | input | 1 | Processor memory write strobe, active high |
| cpu_dout | input | DATA_W | Byte the processor drives for a write |
| en_pin | input | 1 | Transfer enable from a port pin |
| dir_in | input | 1 | Direction select: 0 memory to peripheral, 1 peripheral to memory |
| mem_rdata | input | DATA_W | Byte the memory drives during a read |
| per_din | input | DATA_W | Byte the peripheral offers |
| per_wr | output | 1 | Peripheral write (capture) strobe |
| per_rd | output | 1 | Peripheral read (drive) strobe |
| per_dout | output | DATA_W | Bus byte presented to the peripheral |
| mem_wdata | output | DATA_W | Byte written into memory |
| mem_addr | output | ADDR_W-TAG_W | Memory address with the tag bits removed |
| cpu_drv_en | output | 1 | Enable for the processor's bus switch |
| cpu_wait | output | 1 | Wait-state request to the processor |

## Verification
A seeded random walk mixes idle cycles, multi-cycle reads and writes, pin and address-tag enables, and direction flips. This separates the enabled cases from the disabled ones and the matching directions from the crossed ones. Directed runs then cover four things: a strobe in the first cycle after reset, which shows the reset direction; an enable from the address tag alone, which shows that the decoder is independent of the pin; a direction flip held during a long read, which must not take effect until the bus goes idle; and a long input write, which shows that the wait request covers only its first cycle.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic {XFER_OUT = 1'b0, XFER_IN = 1'b1} xfer_dir_e;
  localparam int EN_PIN  = 0;
  localparam int EN_ADDR = 1;
  localparam int EN_ANY  = 2;
endpackage

// File: rtl/pdma_en_decode.sv
module pdma_en_decode #(
  parameter int            TAG_W   = 1,
  parameter logic [TAG_W-1:0] TAG_VAL = '1,
  parameter int            EN_MODE = 2
) (
  input  logic [TAG_W-1:0] tag,
  input  logic             en_pin,
  output logic             dma_en
);
  import pdma_pkg::*;

  logic tag_hit;
  assign tag_hit = (tag == TAG_VAL);

  generate
    if (EN_MODE == EN_PIN) begin : g_pin
      assign dma_en = en_pin;
    end else if (EN_MODE == EN_ADDR) begin : g_addr
      assign dma_en = tag_hit;
    end else begin : g_any
      assign dma_en = en_pin | tag_hit;
    end
  endgenerate
endmodule

// File: rtl/pdma_xfer_ctl.sv
module pdma_xfer_ctl #(
  parameter int WAIT_CYC = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic                 dir_in,
  input  logic                 in_strobe,
  output pdma_pkg::xfer_dir_e  dir_q,
  output logic                 wait_req
);
  import pdma_pkg::*;

  localparam int CNT_W = $clog2(WAIT_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAIT_CYC);

  logic             bus_idle;
  logic [CNT_W-1:0] wcnt;

  assign bus_idle = ~(cpu_rd | cpu_wr);

  // direction only follows the select while the bus is idle
  always_ff @(posedge clk) begin
    if (rst)
      dir_q <= XFER_OUT;
    else if (bus_idle)
      dir_q <= xfer_dir_e'(dir_in);
  end

  // counts cycles of a continuous input strobe, saturating
  always_ff @(posedge clk) begin
    if (rst)
      wcnt <= '0;
    else if (!in_strobe)
      wcnt <= '0;
    else if (wcnt != CNT_MAX)
      wcnt <= wcnt + 1'b1;
  end

  assign wait_req = in_strobe & (wcnt < CNT_MAX);
endmodule

// File: rtl/pdma_bus_arb.sv
module pdma_bus_arb #(
  parameter int DATA_W = 8
) (
  input  logic                dma_en,
  input  pdma_pkg::xfer_dir_e dir_q,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  input  logic [DATA_W-1:0]   cpu_dout,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic [DATA_W-1:0]   per_din,
  output logic                per_wr,
  output logic                per_rd,
  output logic [DATA_W-1:0]   per_dout,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                cpu_drv_en
);
  import pdma_pkg::*;

  logic take_out, take_in;

  always_comb begin
    take_out   = dma_en & (dir_q == XFER_OUT);
    take_in    = dma_en & (dir_q == XFER_IN);
    per_wr     = cpu_rd & take_out;
    per_rd     = cpu_wr & take_in;
    per_dout   = mem_rdata;
    mem_wdata  = per_rd ? per_din : cpu_dout;
    cpu_drv_en = cpu_wr & ~per_rd;
  end
endmodule

// File: rtl/pdma_bridge.sv
module pdma_bridge #(
  parameter int               ADDR_W   = 16,
  parameter int               DATA_W   = 8,
  parameter int               TAG_W    = 1,
  parameter logic [TAG_W-1:0] TAG_VAL  = '1,
  parameter int               EN_MODE  = 2,
  parameter int               WAIT_CYC = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    cpu_rd,
  input  logic                    cpu_wr,
  input  logic [DATA_W-1:0]       cpu_dout,
  input  logic                    en_pin,
  input  logic                    dir_in,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic [DATA_W-1:0]       per_din,
  output logic                    per_wr,
  output logic                    per_rd,
  output logic [DATA_W-1:0]       per_dout,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic [ADDR_W-TAG_W-1:0] mem_addr,
  output logic                    cpu_drv_en,
  output logic                    cpu_wait
);
  import pdma_pkg::*;

  localparam int MEM_AW = ADDR_W - TAG_W;

  logic      dma_en;
  xfer_dir_e dir_q;

  assign mem_addr = cpu_addr[MEM_AW-1:0];

  pdma_en_decode #(
    .TAG_W(TAG_W), .TAG_VAL(TAG_VAL), .EN_MODE(EN_MODE)
  ) u_dec (
    .tag    (cpu_addr[ADDR_W-1:MEM_AW]),
    .en_pin (en_pin),
    .dma_en (dma_en)
  );

  pdma_bus_arb #(.DATA_W(DATA_W)) u_arb (
    .dma_en     (dma_en),
    .dir_q      (dir_q),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_dout   (cpu_dout),
    .mem_rdata  (mem_rdata),
    .per_din    (per_din),
    .per_wr     (per_wr),
    .per_rd     (per_rd),
    .per_dout   (per_dout),
    .mem_wdata  (mem_wdata),
    .cpu_drv_en (cpu_drv_en)
  );

  pdma_xfer_ctl #(.WAIT_CYC(WAIT_CYC)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .dir_in    (dir_in),
    .in_strobe (per_rd),
    .dir_q     (dir_q),
    .wait_req  (cpu_wait)
  );
endmodule

// File: rtl/pdma_bridge_chk.sv
module pdma_bridge_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              dma_en,
  input logic              dir_q,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] per_din,
  input logic [DATA_W-1:0] per_dout,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              per_wr,
  input logic              per_rd,
  input logic              cpu_drv_en,
  input logic              cpu_wait
);
  p_out_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    (dma_en && cpu_rd && !dir_q) |-> (per_wr && per_dout == mem_rdata));

  p_in_drive_r2: assert property (@(posedge clk) disable iff (rst)
    per_rd |-> (!cpu_drv_en && mem_wdata == per_din));

  p_no_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !dma_en |-> (!per_wr && !per_rd));

  p_wait_only_in_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_wait |-> per_rd);

  p_wait_first_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(per_rd) |-> cpu_wait);

  p_dir_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd || cpu_wr) |=> $stable(dir_q));

  p_no_cross_r9: assert property (@(posedge clk) disable iff (rst)
    !(per_wr && per_rd));
endmodule

bind pdma_bridge pdma_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .dma_en(dma_en), .dir_q(dir_q), .mem_rdata(mem_rdata),
  .per_din(per_din), .per_dout(per_dout), .mem_wdata(mem_wdata),
  .per_wr(per_wr), .per_rd(per_rd), .cpu_drv_en(cpu_drv_en),
  .cpu_wait(cpu_wait)
);

// File: tb/pdma_bridge_tb_top.sv
`timescale 1ns/1ps
module pdma_bridge_tb_top;
  localparam int WAITC = 1;

  logic        clk = 0;
  logic        rst = 1;
  logic [15:0] cpu_addr = 0;
  logic        cpu_rd = 0, cpu_wr = 0, en_pin = 0, dir_in = 0;
  logic [7:0]  cpu_dout = 0, mem_rdata = 0, per_din = 0;
  logic        per_wr, per_rd, cpu_drv_en, cpu_wait;
  logic [7:0]  per_dout, mem_wdata;
  logic [14:0] mem_addr;

  int total = 0, bad = 0;
  logic m_dir = 0;
  int   m_cnt = 0;

  always #4 clk = ~clk;

  pdma_bridge dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_dout(cpu_dout), .en_pin(en_pin),
    .dir_in(dir_in), .mem_rdata(mem_rdata), .per_din(per_din),
    .per_wr(per_wr), .per_rd(per_rd), .per_dout(per_dout),
    .mem_wdata(mem_wdata), .mem_addr(mem_addr),
    .cpu_drv_en(cpu_drv_en), .cpu_wait(cpu_wait)
  );

  function automatic logic f_en(logic pin, logic [15:0] a);
    return pin | a[15];
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // apply inputs at the falling edge, check, then advance the model
  task automatic step(logic r, logic w, logic [15:0] a, logic pin, logic d,
                      logic [7:0] dout, logic [7:0] rdat, logic [7:0] pdin);
    logic e, xw, xr, xwait;
    @(negedge clk);
    rst = 0; cpu_rd = r; cpu_wr = w; cpu_addr = a; en_pin = pin;
    dir_in = d; cpu_dout = dout; mem_rdata = rdat; per_din = pdin;
    #2;
    e     = f_en(pin, a);
    xw    = r & e & (m_dir == 1'b0);
    xr    = w & e & (m_dir == 1'b1);
    xwait = xr & (m_cnt < WAITC);
    chk(!e ? "R4 per_wr" : (r && m_dir) ? "R9 per_wr" : "R1 per_wr",
        int'(per_wr), int'(xw));
    chk(!e ? "R4 per_rd" : (w && !m_dir) ? "R9 per_rd" : "R2 per_rd",
        int'(per_rd), int'(xr));
    chk("R1 per_dout", int'(per_dout), int'(rdat));
    chk(xr ? "R2 mem_wdata" : "R3 mem_wdata", int'(mem_wdata),
        int'(xr ? pdin : dout));
    chk(xr ? "R2 cpu_drv_en" : "R3 cpu_drv_en", int'(cpu_drv_en),
        int'(w & ~xr));
    chk("R6 cpu_wait", int'(cpu_wait), int'(xwait));
    chk("R5 mem_addr", int'(mem_addr), int'(a[14:0]));
    @(posedge clk);
    if (!r && !w) m_dir = d;
    m_cnt = xr ? ((m_cnt < WAITC) ? m_cnt + 1 : m_cnt) : 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic r, w, d, pin;
    logic [15:0] a;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(posedge clk);
    m_dir = 0; m_cnt = 0;
    // R8: strobe in the first cycle after reset, select already 1 -> still output
    step(1, 0, 16'h0010, 1, 1, 8'hFF, 8'h3C, 8'h00);
    step(0, 0, 16'h0000, 0, 1, 8'hFF, 8'h00, 8'h00);
    // R8 idle outputs after a fresh reset
    @(negedge clk); rst = 1; cpu_rd = 0; cpu_wr = 0;
    @(posedge clk); m_dir = 0; m_cnt = 0;
    @(negedge clk); rst = 0; #2;
    chk("R8 per_wr idle", int'(per_wr), 0);
    chk("R8 per_rd idle", int'(per_rd), 0);
    chk("R8 cpu_wait idle", int'(cpu_wait), 0);
    @(posedge clk); m_dir = dir_in;
    // R5: enable from address tag alone, output direction
    step(0, 0, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00);
    step(1, 0, 16'h8123, 0, 0, 8'h00, 8'hA5, 8'h00);
    // R4: same read without tag or pin
    step(1, 0, 16'h0123, 0, 0, 8'h00, 8'h5A, 8'h00);
    // R7: direction flips during a long read
    step(0, 0, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00);
    step(1, 0, 16'h8001, 0, 1, 8'h00, 8'h11, 8'h00);
    step(1, 0, 16'h8002, 0, 1, 8'h00, 8'h22, 8'h00);
    step(1, 0, 16'h8003, 0, 1, 8'h00, 8'h33, 8'h00);
    // R9: write in output direction gives no peripheral read
    step(0, 1, 16'h8004, 1, 1, 8'hFF, 8'h00, 8'h77);
    // idle picks up input direction, then R6 long input write
    step(0, 0, 16'h0000, 0, 1, 8'h00, 8'h00, 8'h00);
    step(0, 1, 16'h8005, 0, 0, 8'hFF, 8'h00, 8'hC3);
    step(0, 1, 16'h8005, 0, 0, 8'hFF, 8'h00, 8'hC3);
    step(0, 1, 16'h8005, 0, 0, 8'hFF, 8'h00, 8'hC3);
    // R9: read in input direction gives no peripheral write
    step(1, 0, 16'h0006, 1, 1, 8'h00, 8'h99, 8'h00);
    // random walk
    r = 0; w = 0; d = 1; pin = 0; a = 0;
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(1, 0) == 0) begin
        case ($urandom_range(2, 0))
          0: begin r = 0; w = 0; end
          1: begin r = 1; w = 0; end
          default: begin r = 0; w = 1; end
        endcase
        a = 16'($urandom);
        pin = 1'($urandom);
      end
      if ($urandom_range(3, 0) == 0) d = ~d;
      step(r, w, a, pin, d, 8'($urandom), 8'($urandom), 8'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule